// File: doc/BRIEF.md
# Hybrid SRAM / Non-Volatile Cache Set Placement Controller

This block makes the placement and migration decisions for a single set of an eight-way last-level cache. The set mixes two kinds of storage. The two lowest ways are SRAM, which is fast to write. The six upper ways are STT-MRAM, which is non-volatile. Some of the non-volatile ways sit in regions where process variation makes read sensing unreliable. A per-way flag marks those ways, and the flags are loaded once after self-test. For each way the controller keeps a valid bit and two saturating 4-bit counters, one for read hits and one for write hits. It also keeps an 8-entry, fully associative profiler of addresses that have shown heavy read use, with true-LRU replacement.

Each cycle the surrounding cache presents at most one access. The access carries hit or miss, read or write, the hit way, the block address and the current LRU rank of every way. The controller answers in the same cycle. On a miss it names the way to fill. On a hit it may request that two ways exchange their blocks. The two cases are a heavily read block leaving an unreliable non-volatile way, and a heavily written block moving into SRAM. Counter, valid and profiler updates take effect at the next clock edge. The read and write thresholds are inputs that come from configuration registers held elsewhere. Tag matching, data movement and memory fetch are done outside this block.

Top module: `hpc_ctrl`

## Requirements
- R1: While reset is low, `fill_vld`, `mig_vld` and `prof_hit` stay 0 even if an access is presented. After reset, every counter reads 0, `way_vld` is 0 and the profiler holds no address.
- R2: A write miss sets `fill_vld` and chooses, among ways 0 and 1, the way with the larger `lru_rank` value. Rank 7 means least recently used. A fill and a migration never occur in the same cycle.
- R3: A read miss whose address is in the profiler (`prof_hit`=1) fills the least recently used way among ways 2 to 7 whose variation flag is 0. If every such way has flag 1, it fills the least recently used way among ways 2 to 7.
- R4: A read miss whose address is not in the profiler fills the least recently used way among ways 2 to 7.
- R5: A read hit whose address is in the profiler raises `prof_hit` and refreshes only that entry's recency. It changes no counter and requests no migration.
- R6: A read hit whose address is not in the profiler, when all 8 profiler entries are occupied, replaces the least recently used profiler entry with this address. It changes no counter.
- R7: A read hit that matches neither of the two profiler cases above, with a read counter below `cfg_rd_limit`, increments that way's read counter by one.
- R8: A read hit whose read counter has reached `cfg_rd_limit`, with the profiler neither matching nor full, inserts the address into the profiler. If the hit way is in 2 to 7 with flag 1, it also requests a migration. The source is the hit way. The destination is the least recently used way among ways 2 to 7 with flag 0 and a read counter below `cfg_rd_limit`.
- R9: If no way qualifies as destination in R8, no migration is requested. The address is still inserted into the profiler.
- R10: A write hit to a way in 2 to 7 whose write counter is below `cfg_wr_limit` increments that counter by one. A write hit to way 0 or 1 changes nothing.
- R11: A write hit to a way in 2 to 7 whose write counter has reached `cfg_wr_limit` requests a migration. The source is the hit way. The destination is the least recently used of ways 0 and 1.
- R12: A fill clears both counters of the filled way and sets its `way_vld` bit. A migration clears both counters of the source way and of the destination way. Counters saturate at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rd_limit | input | 4 | Read-intensity threshold |
| cfg_wr_limit | input | 4 | Write-intensity threshold |
| var_load | input | 1 | Load the variation flags this cycle |
| var_flags | input | 8 | Per-way high-variation flags; bits 0 and 1 are ignored |
| acc_valid | input | 1 | An access is presented |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_way | input | 3 | Way that hit (ignored on a miss) |
| acc_addr | input | 16 | Block address for profiler lookup |
| lru_rank | input | 24 | Rank of way w in bits [3w+2:3w], 0 = most recent, 7 = least recent |
| fill_vld | output | 1 | Fill way is valid |
| fill_way | output | 3 | Way to fill on a miss |
| mig_vld | output | 1 | Swap request |
| mig_src | output | 3 | Way holding the block to move |
| mig_dst | output | 3 | Way it exchanges with |
| prof_hit | output | 1 | Access address is present in the profiler |
| rd_cnt | output | 32 | Read counter of way w in bits [4w+3:4w] |
| wr_cnt | output | 32 | Write counter of way w in bits [4w+3:4w] |
| way_vld | output | 8 | Valid bit per way |

## Verification
On one read hit, a read-intensive block can be inserted into the profiler and can also trigger a swap request. These are two separate functions that fire together. The bench reaches that case by presenting repeated read hits to a flagged non-volatile way until its counter meets the read limit. In the promoting cycle it checks the source and destination ports. It then checks that both counters were cleared after the edge. A later read miss to the same address must report `prof_hit` and land on a low-variation way, which confirms the insertion. The reverse case, insertion without a swap because no partner exists, is provoked by flagging every non-volatile way and is judged the same way.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  // Decision taken for the access presented this cycle.
  typedef enum logic [3:0] {
    ACT_IDLE,
    ACT_FILL_SRAM,
    ACT_FILL_SAFE,
    ACT_FILL_NVM,
    ACT_PROF_TOUCH,
    ACT_PROF_REPLACE,
    ACT_RD_BUMP,
    ACT_RD_PROMOTE,
    ACT_WR_BUMP,
    ACT_WR_TO_SRAM,
    ACT_WR_SRAM_HIT
  } act_e;

endpackage

// File: rtl/hpc_prof.sv
module hpc_prof #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              touch_en,
  input  logic              ins_en,
  output logic              hit,
  output logic              full
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [IDX_W-1:0]  age_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic [IDX_W-1:0]  tgt_idx;
  logic [OCC_W-1:0]  occ;
  logic [OCC_W-1:0]  ref_age;
  logic              upd;

  function automatic logic [OCC_W-1:0] pop_count(input logic [DEPTH-1:0] v);
    logic [OCC_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + OCC_W'(v[i]);
    return n;
  endfunction

  always_comb begin
    logic found;
    found   = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && vld_q[i] && tag_q[i] == look_addr) begin
        found   = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    hit = found;
  end

  assign occ  = pop_count(vld_q);
  assign full = &vld_q;

  // Oldest entry when full, otherwise the first empty slot.
  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && (full ? (age_q[i] == IDX_W'(DEPTH - 1)) : !vld_q[i])) begin
        found      = 1'b1;
        victim_idx = IDX_W'(i);
      end
    end
  end

  assign upd     = touch_en | ins_en;
  assign tgt_idx = touch_en ? hit_idx : victim_idx;
  assign ref_age = touch_en ? OCC_W'(age_q[hit_idx])
                 : (full ? OCC_W'(DEPTH - 1) : occ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        age_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else if (upd) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (tgt_idx == IDX_W'(i)) begin
          age_q[i] <= '0;
          vld_q[i] <= 1'b1;
          if (ins_en) tag_q[i] <= look_addr;
        end else if (vld_q[i] && OCC_W'(age_q[i]) < ref_age) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hpc_way_state.sv
module hpc_way_state #(
  parameter int WAYS      = 8,
  parameter int SRAM_WAYS = 2,
  parameter int CNT_W     = 4,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flag_ld,
  input  logic [WAYS-1:0]       flag_in,
  input  logic                  rc_bump,
  input  logic                  wc_bump,
  input  logic [WAY_W-1:0]      bump_way,
  input  logic                  clr_a,
  input  logic [WAY_W-1:0]      clr_a_way,
  input  logic                  clr_b,
  input  logic [WAY_W-1:0]      clr_b_way,
  input  logic                  fill_set,
  output logic [WAYS*CNT_W-1:0] rc_flat,
  output logic [WAYS*CNT_W-1:0] wc_flat,
  output logic [WAYS-1:0]       vld,
  output logic [WAYS-1:0]       flag
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    localparam bit IS_NVM = (g >= SRAM_WAYS);
    logic [CNT_W-1:0] rc_r;
    logic [CNT_W-1:0] wc_r;
    logic             vld_r;
    logic             flag_r;
    logic             sel_a;
    logic             sel_b;
    logic             sel_bump;

    assign sel_a    = clr_a && clr_a_way == WAY_W'(g);
    assign sel_b    = clr_b && clr_b_way == WAY_W'(g);
    assign sel_bump = bump_way == WAY_W'(g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rc_r   <= '0;
        wc_r   <= '0;
        vld_r  <= 1'b0;
        flag_r <= 1'b0;
      end else begin
        if (flag_ld) flag_r <= flag_in[g] & IS_NVM;
        if (sel_a || sel_b) begin
          rc_r <= '0;
          wc_r <= '0;
        end else begin
          if (rc_bump && sel_bump) rc_r <= sat_inc(rc_r);
          if (wc_bump && sel_bump && IS_NVM) wc_r <= sat_inc(wc_r);
        end
        if (fill_set && sel_a) vld_r <= 1'b1;
      end
    end

    assign rc_flat[g*CNT_W +: CNT_W] = rc_r;
    assign wc_flat[g*CNT_W +: CNT_W] = wc_r;
    assign vld[g]                    = vld_r;
    assign flag[g]                   = flag_r;
  end

endmodule

// File: rtl/hpc_decide.sv
module hpc_decide
  import hpc_pkg::*;
#(
  parameter int WAYS      = 8,
  parameter int SRAM_WAYS = 2,
  parameter int CNT_W     = 4,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic                  go,
  input  logic                  is_hit,
  input  logic                  is_wr,
  input  logic [WAY_W-1:0]      way,
  input  logic [WAYS*WAY_W-1:0] rank_flat,
  input  logic [WAYS*CNT_W-1:0] rc_flat,
  input  logic [WAYS*CNT_W-1:0] wc_flat,
  input  logic [WAYS-1:0]       flags,
  input  logic [CNT_W-1:0]      rd_limit,
  input  logic [CNT_W-1:0]      wr_limit,
  input  logic                  prof_hit,
  input  logic                  prof_full,
  output logic                  fill_vld,
  output logic [WAY_W-1:0]      fill_way,
  output logic                  mig_vld,
  output logic [WAY_W-1:0]      mig_src,
  output logic [WAY_W-1:0]      mig_dst,
  output logic                  rc_bump,
  output logic                  wc_bump,
  output logic                  prof_touch,
  output logic                  prof_ins,
  output logic                  ev_promote,
  output logic                  ev_partner,
  output act_e                  act
);

  localparam logic [WAYS-1:0] SRAM_MASK = WAYS'((1 << SRAM_WAYS) - 1);
  localparam logic [WAYS-1:0] NVM_MASK  = ~SRAM_MASK;

  // Oldest way in a mask: {found, way}.
  function automatic logic [WAY_W:0] pick_oldest(input logic [WAYS-1:0] m,
                                                 input logic [WAYS*WAY_W-1:0] r);
    logic             found;
    logic [WAY_W-1:0] w;
    logic [WAY_W-1:0] best;
    found = 1'b0;
    w     = '0;
    best  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (m[i] && (!found || r[i*WAY_W +: WAY_W] > best)) begin
        found = 1'b1;
        w     = WAY_W'(i);
        best  = r[i*WAY_W +: WAY_W];
      end
    end
    return {found, w};
  endfunction

  logic [WAYS-1:0]  below_rd;
  logic [WAYS-1:0]  safe_mask;
  logic [WAYS-1:0]  partner_mask;
  logic [WAY_W:0]   sram_pick;
  logic [WAY_W:0]   nvm_pick;
  logic [WAY_W:0]   safe_pick;
  logic [WAY_W:0]   partner_pick;
  logic [CNT_W-1:0] hit_rc;
  logic [CNT_W-1:0] hit_wc;
  logic             hit_nvm;
  logic             hit_flag;

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      below_rd[i] = rc_flat[i*CNT_W +: CNT_W] < rd_limit;
    end
  end

  assign safe_mask    = NVM_MASK & ~flags;
  assign partner_mask = safe_mask & below_rd;
  assign sram_pick    = pick_oldest(SRAM_MASK, rank_flat);
  assign nvm_pick     = pick_oldest(NVM_MASK, rank_flat);
  assign safe_pick    = pick_oldest(safe_mask, rank_flat);
  assign partner_pick = pick_oldest(partner_mask, rank_flat);

  assign hit_rc   = rc_flat[way*CNT_W +: CNT_W];
  assign hit_wc   = wc_flat[way*CNT_W +: CNT_W];
  assign hit_nvm  = NVM_MASK[way];
  assign hit_flag = flags[way];
  assign ev_partner = partner_pick[WAY_W];

  always_comb begin
    fill_vld   = 1'b0;
    fill_way   = '0;
    mig_vld    = 1'b0;
    mig_src    = '0;
    mig_dst    = '0;
    rc_bump    = 1'b0;
    wc_bump    = 1'b0;
    prof_touch = 1'b0;
    prof_ins   = 1'b0;
    ev_promote = 1'b0;
    act        = ACT_IDLE;
    if (go) begin
      if (!is_hit) begin
        fill_vld = 1'b1;
        if (is_wr) begin
          fill_way = sram_pick[WAY_W-1:0];
          act      = ACT_FILL_SRAM;
        end else if (prof_hit && safe_pick[WAY_W]) begin
          fill_way = safe_pick[WAY_W-1:0];
          act      = ACT_FILL_SAFE;
        end else begin
          fill_way = nvm_pick[WAY_W-1:0];
          act      = ACT_FILL_NVM;
        end
      end else if (!is_wr) begin
        if (prof_hit) begin
          prof_touch = 1'b1;
          act        = ACT_PROF_TOUCH;
        end else if (prof_full) begin
          prof_ins = 1'b1;
          act      = ACT_PROF_REPLACE;
        end else if (hit_rc < rd_limit) begin
          rc_bump = 1'b1;
          act     = ACT_RD_BUMP;
        end else begin
          prof_ins   = 1'b1;
          ev_promote = 1'b1;
          act        = ACT_RD_PROMOTE;
          if (hit_nvm && hit_flag && partner_pick[WAY_W]) begin
            mig_vld = 1'b1;
            mig_src = way;
            mig_dst = partner_pick[WAY_W-1:0];
          end
        end
      end else begin
        if (!hit_nvm) begin
          act = ACT_WR_SRAM_HIT;
        end else if (hit_wc < wr_limit) begin
          wc_bump = 1'b1;
          act     = ACT_WR_BUMP;
        end else begin
          mig_vld = 1'b1;
          mig_src = way;
          mig_dst = sram_pick[WAY_W-1:0];
          act     = ACT_WR_TO_SRAM;
        end
      end
    end
  end

endmodule

// File: rtl/hpc_ctrl.sv
module hpc_ctrl
  import hpc_pkg::*;
#(
  parameter int WAYS       = 8,
  parameter int SRAM_WAYS  = 2,
  parameter int CNT_W      = 4,
  parameter int ADDR_W     = 16,
  parameter int PROF_DEPTH = 8,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      cfg_rd_limit,
  input  logic [CNT_W-1:0]      cfg_wr_limit,
  input  logic                  var_load,
  input  logic [WAYS-1:0]       var_flags,
  input  logic                  acc_valid,
  input  logic                  acc_hit,
  input  logic                  acc_write,
  input  logic [WAY_W-1:0]      acc_way,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [WAYS*WAY_W-1:0] lru_rank,
  output logic                  fill_vld,
  output logic [WAY_W-1:0]      fill_way,
  output logic                  mig_vld,
  output logic [WAY_W-1:0]      mig_src,
  output logic [WAY_W-1:0]      mig_dst,
  output logic                  prof_hit,
  output logic [WAYS*CNT_W-1:0] rd_cnt,
  output logic [WAYS*CNT_W-1:0] wr_cnt,
  output logic [WAYS-1:0]       way_vld
);

  // Named internal events.
  logic       go;
  logic       look_hit;
  logic       look_full;
  logic       rc_bump;
  logic       wc_bump;
  logic       prof_touch;
  logic       prof_ins;
  logic       ev_promote;
  logic       ev_partner;
  logic [WAYS-1:0] flags;
  act_e       act;

  assign go       = acc_valid & rst_n;
  assign prof_hit = go & look_hit;

  hpc_prof #(
    .ADDR_W (ADDR_W),
    .DEPTH  (PROF_DEPTH)
  ) prof_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_addr (acc_addr),
    .touch_en  (prof_touch),
    .ins_en    (prof_ins),
    .hit       (look_hit),
    .full      (look_full)
  );

  hpc_decide #(
    .WAYS      (WAYS),
    .SRAM_WAYS (SRAM_WAYS),
    .CNT_W     (CNT_W)
  ) decide_i (
    .go         (go),
    .is_hit     (acc_hit),
    .is_wr      (acc_write),
    .way        (acc_way),
    .rank_flat  (lru_rank),
    .rc_flat    (rd_cnt),
    .wc_flat    (wr_cnt),
    .flags      (flags),
    .rd_limit   (cfg_rd_limit),
    .wr_limit   (cfg_wr_limit),
    .prof_hit   (look_hit),
    .prof_full  (look_full),
    .fill_vld   (fill_vld),
    .fill_way   (fill_way),
    .mig_vld    (mig_vld),
    .mig_src    (mig_src),
    .mig_dst    (mig_dst),
    .rc_bump    (rc_bump),
    .wc_bump    (wc_bump),
    .prof_touch (prof_touch),
    .prof_ins   (prof_ins),
    .ev_promote (ev_promote),
    .ev_partner (ev_partner),
    .act        (act)
  );

  hpc_way_state #(
    .WAYS      (WAYS),
    .SRAM_WAYS (SRAM_WAYS),
    .CNT_W     (CNT_W)
  ) state_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_ld   (var_load),
    .flag_in   (var_flags),
    .rc_bump   (rc_bump),
    .wc_bump   (wc_bump),
    .bump_way  (acc_way),
    .clr_a     (fill_vld | mig_vld),
    .clr_a_way (fill_vld ? fill_way : mig_src),
    .clr_b     (mig_vld),
    .clr_b_way (mig_dst),
    .fill_set  (fill_vld),
    .rc_flat   (rd_cnt),
    .wc_flat   (wr_cnt),
    .vld       (way_vld),
    .flag      (flags)
  );

endmodule

// File: rtl/hpc_ctrl_chk.sv
module hpc_ctrl_chk #(
  parameter int WAYS      = 8,
  parameter int SRAM_WAYS = 2,
  parameter int CNT_W     = 4,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CNT_W-1:0]      cfg_rd_limit,
  input logic [CNT_W-1:0]      cfg_wr_limit,
  input logic                  acc_valid,
  input logic                  acc_hit,
  input logic                  acc_write,
  input logic [WAY_W-1:0]      acc_way,
  input logic                  fill_vld,
  input logic [WAY_W-1:0]      fill_way,
  input logic                  mig_vld,
  input logic [WAY_W-1:0]      mig_src,
  input logic [WAY_W-1:0]      mig_dst,
  input logic [WAYS*CNT_W-1:0] rd_cnt,
  input logic [WAYS*CNT_W-1:0] wr_cnt
);

  function automatic logic [CNT_W-1:0] cnt_at(input logic [WAYS*CNT_W-1:0] f,
                                              input logic [WAY_W-1:0] w);
    return f[w*CNT_W +: CNT_W];
  endfunction

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !fill_vld && !mig_vld); // R1

  AST_FILL_MIG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |-> !mig_vld && acc_valid && !acc_hit); // R2

  AST_WR_MISS_TO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld && acc_write |-> int'(fill_way) < SRAM_WAYS); // R2

  AST_RD_MISS_TO_NVM: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld && !acc_write |-> int'(fill_way) >= SRAM_WAYS); // R4

  AST_FILL_ZEROES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld |=> cnt_at(rd_cnt, $past(fill_way)) == '0 &&
                 cnt_at(wr_cnt, $past(fill_way)) == '0); // R12

  AST_WR_BUMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_hit && acc_write && int'(acc_way) >= SRAM_WAYS &&
    cnt_at(wr_cnt, acc_way) < cfg_wr_limit
    |=> cnt_at(wr_cnt, $past(acc_way)) == $past(cnt_at(wr_cnt, acc_way)) + 1'b1); // R10

  AST_WR_MIG_TO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    mig_vld && acc_write |-> int'(mig_dst) < SRAM_WAYS && mig_src == acc_way &&
                             cnt_at(wr_cnt, acc_way) >= cfg_wr_limit); // R11

  AST_RD_MIG_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    mig_vld && !acc_write |-> int'(mig_src) >= SRAM_WAYS && int'(mig_dst) >= SRAM_WAYS &&
                              mig_src == acc_way && mig_src != mig_dst &&
                              cnt_at(rd_cnt, mig_dst) < cfg_rd_limit); // R8

  AST_MIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mig_vld |=> cnt_at(rd_cnt, $past(mig_src)) == '0 &&
                cnt_at(rd_cnt, $past(mig_dst)) == '0 &&
                cnt_at(wr_cnt, $past(mig_dst)) == '0); // R12

endmodule

bind hpc_ctrl hpc_ctrl_chk #(
  .WAYS      (WAYS),
  .SRAM_WAYS (SRAM_WAYS),
  .CNT_W     (CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rd_limit (cfg_rd_limit),
  .cfg_wr_limit (cfg_wr_limit),
  .acc_valid    (acc_valid),
  .acc_hit      (acc_hit),
  .acc_write    (acc_write),
  .acc_way      (acc_way),
  .fill_vld     (fill_vld),
  .fill_way     (fill_way),
  .mig_vld      (mig_vld),
  .mig_src      (mig_src),
  .mig_dst      (mig_dst),
  .rd_cnt       (rd_cnt),
  .wr_cnt       (wr_cnt)
);

// File: tb/hpc_ctrl_tb_top.sv
`timescale 1ns/1ps
module hpc_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_rd_limit;
  logic [3:0]  cfg_wr_limit;
  logic        var_load;
  logic [7:0]  var_flags;
  logic        acc_valid;
  logic        acc_hit;
  logic        acc_write;
  logic [2:0]  acc_way;
  logic [15:0] acc_addr;
  logic [23:0] lru_rank;
  logic        fill_vld;
  logic [2:0]  fill_way;
  logic        mig_vld;
  logic [2:0]  mig_src;
  logic [2:0]  mig_dst;
  logic        prof_hit;
  logic [31:0] rd_cnt;
  logic [31:0] wr_cnt;
  logic [7:0]  way_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  hpc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rd_limit(cfg_rd_limit), .cfg_wr_limit(cfg_wr_limit),
    .var_load(var_load), .var_flags(var_flags), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_write(acc_write), .acc_way(acc_way), .acc_addr(acc_addr), .lru_rank(lru_rank),
    .fill_vld(fill_vld), .fill_way(fill_way), .mig_vld(mig_vld), .mig_src(mig_src),
    .mig_dst(mig_dst), .prof_hit(prof_hit), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
    .way_vld(way_vld)
  );

  // hit, write, way, addr | fill_vld, fill_way, mig_vld, mig_src, mig_dst, prof_hit
  // Ranks: way w has rank w, so way 1 is the oldest SRAM way and way 7 the oldest overall.
  // Limits 2/2, ways 6 and 7 flagged high-variation.
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd0, 16'h0010, 1'b1, 3'd1, 1'b0, 3'd0, 3'd0, 1'b0}, // R2 write miss
    {1'b0, 1'b0, 3'd0, 16'h0020, 1'b1, 3'd7, 1'b0, 3'd0, 3'd0, 1'b0}, // R4 read miss
    {1'b1, 1'b0, 3'd7, 16'h0020, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0}, // R7 bump to 1
    {1'b1, 1'b0, 3'd7, 16'h0020, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0}, // R7 bump to 2
    {1'b1, 1'b0, 3'd7, 16'h0020, 1'b0, 3'd0, 1'b1, 3'd7, 3'd5, 1'b0}, // R8 promote+swap
    {1'b0, 1'b0, 3'd0, 16'h0020, 1'b1, 3'd5, 1'b0, 3'd0, 3'd0, 1'b1}, // R3 profiled miss
    {1'b1, 1'b0, 3'd3, 16'h0020, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b1}, // R5 touch
    {1'b1, 1'b1, 3'd4, 16'h0030, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0}, // R10 bump
    {1'b1, 1'b1, 3'd4, 16'h0030, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0}, // R10 bump
    {1'b1, 1'b1, 3'd4, 16'h0030, 1'b0, 3'd0, 1'b1, 3'd4, 3'd1, 1'b0}, // R11 to SRAM
    {1'b1, 1'b1, 3'd0, 16'h0040, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 1'b0}, // R10 SRAM hit
    {1'b0, 1'b1, 3'd0, 16'h0050, 1'b1, 3'd1, 1'b0, 3'd0, 3'd0, 1'b0}  // R2 write miss
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rc_of(input int w);
    return int'(rd_cnt[w*4 +: 4]);
  endfunction

  function automatic int wc_of(input int w);
    return int'(wr_cnt[w*4 +: 4]);
  endfunction

  // Present an access after the falling edge; outputs are then settled.
  task automatic issue(input bit h, input bit w, input int way, input int addr);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_hit   = h;
    acc_write = w;
    acc_way   = 3'(way);
    acc_addr  = 16'(addr);
    #1;
  endtask

  // Commit the presented access at the rising edge, then withdraw it.
  task automatic tick();
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
  endtask

  task automatic load_flags(input logic [7:0] f);
    @(negedge clk);
    var_load  = 1'b1;
    var_flags = f;
    @(posedge clk);
    #1;
    var_load = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_rd_limit = 4'd2; cfg_wr_limit = 4'd2;
    var_load = 1'b0; var_flags = '0;
    acc_valid = 1'b0; acc_hit = 1'b0; acc_write = 1'b0; acc_way = '0; acc_addr = '0;
    for (int w = 0; w < 8; w++) lru_rank[w*3 +: 3] = 3'(w);

    // R1: access presented during reset produces nothing.
    repeat (3) @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b1; acc_hit = 1'b0; acc_write = 1'b0; acc_addr = 16'h0020;
    #1;
    chk("R1 fill_vld in reset", int'(fill_vld), 0);
    chk("R1 mig_vld in reset", int'(mig_vld), 0);
    chk("R1 prof_hit in reset", int'(prof_hit), 0);
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b1;
    #1;
    chk("R1 rd_cnt after reset", int'(rd_cnt != 0), 0);
    chk("R1 wr_cnt after reset", int'(wr_cnt != 0), 0);
    chk("R1 way_vld after reset", int'(way_vld), 0);

    load_flags(8'b1100_0000);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      issue(v[32], v[31], int'(v[30:28]), int'(v[27:12]));
      chk($sformatf("row%0d fill_vld", i), int'(fill_vld), int'(v[11]));
      if (v[11]) chk($sformatf("row%0d fill_way", i), int'(fill_way), int'(v[10:8]));
      chk($sformatf("row%0d mig_vld", i), int'(mig_vld), int'(v[7]));
      if (v[7]) begin
        chk($sformatf("row%0d mig_src", i), int'(mig_src), int'(v[6:4]));
        chk($sformatf("row%0d mig_dst", i), int'(mig_dst), int'(v[3:1]));
      end
      chk($sformatf("row%0d prof_hit", i), int'(prof_hit), int'(v[0]));
      tick();
      if (i == 3) chk("R7 read counter of way 7", rc_of(7), 2);
      if (i == 8) chk("R10 write counter of way 4", wc_of(4), 2);
    end

    chk("R12 rc of swap source way 7", rc_of(7), 0);
    chk("R12 wc of write-swap source way 4", wc_of(4), 0);
    chk("R10 SRAM way 0 write counter", wc_of(0), 0);
    chk("R12 way_vld after fills", int'(way_vld), 8'b1010_0010);

    // R7: plain read bump on a clean way.
    issue(1'b1, 1'b0, 2, 16'h0090);
    chk("R7 no migration on bump", int'(mig_vld), 0);
    tick();
    chk("R7 rc of way 2", rc_of(2), 1);

    // R9: all non-volatile ways flagged, so no partner.
    load_flags(8'b1111_1100);
    issue(1'b1, 1'b0, 2, 16'h0090);
    tick();
    issue(1'b1, 1'b0, 2, 16'h0090);
    chk("R9 no partner means no migration", int'(mig_vld), 0);
    tick();
    issue(1'b1, 1'b0, 2, 16'h0090);
    chk("R9 address still inserted", int'(prof_hit), 1);
    chk("R5 no migration on profiled hit", int'(mig_vld), 0);
    tick();
    chk("R5 rc of way 2 unchanged", rc_of(2), 2);

    // R3 fallback: profiled miss with no low-variation way.
    issue(1'b0, 1'b0, 0, 16'h0020);
    chk("R3 profiled miss prof_hit", int'(prof_hit), 1);
    chk("R3 fallback fill way", int'(fill_way), 7);
    tick();

    // R6: fill the profiler (holds 0x20, 0x90) with six more entries.
    cfg_rd_limit = 4'd0;
    for (int k = 0; k < 6; k++) begin
      issue(1'b1, 1'b0, 3, 16'h00A0 + k);
      chk("R9 insert without partner", int'(mig_vld), 0);
      tick();
    end
    issue(1'b1, 1'b0, 3, 16'h0020);
    chk("R5 touch of oldest entry", int'(prof_hit), 1);
    tick();
    issue(1'b1, 1'b0, 3, 16'h00B0);
    chk("R6 new address misses profiler", int'(prof_hit), 0);
    chk("R6 no migration on replace", int'(mig_vld), 0);
    tick();
    chk("R6 rc of way 3 unchanged", rc_of(3), 0);
    issue(1'b1, 1'b0, 3, 16'h00B0);
    chk("R6 replacing address now present", int'(prof_hit), 1);
    tick();
    issue(1'b1, 1'b0, 3, 16'h0020);
    chk("R6 refreshed entry survived", int'(prof_hit), 1);
    tick();
    issue(1'b1, 1'b0, 3, 16'h0090);
    chk("R6 least recent entry evicted", int'(prof_hit), 0);
    tick();

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule